// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

This block is a grid of sixteen one-bit processing elements, four rows by four columns, that all obey a single instruction broadcast each cycle by a central controller. Each element holds a private bit-addressable store of 4096 bits, a one-bit accumulator, a one-bit carry flag and an enable (context) flag. Every datapath, memory read and memory write is a single bit wide. Any wider operation is built by the controller as a sequence of one-bit steps, one step per cycle.

The controller presents an opcode, a 12-bit bit address and a two-bit neighbour direction every cycle, plus a 16-bit lane vector that carries one private data bit to each element. Elements whose enable flag is clear still see the broadcast but keep their store, accumulator and carry untouched. This lets the controller run data-dependent branches across the array. A global OR output tells the controller whether any enabled element holds a set accumulator, so it can branch on array-wide conditions. A 32-bit add, for example, is a clear-carry step followed by 32 rounds of load, add-step and store, least significant bit first.

Top module: `bsa_array`

## Requirements
- R1: After synchronous active-high reset, every accumulator and carry is 0, every enable flag is 1, every store bit is 0, and the global OR output is 0.
- R2: Opcode 2 (load) copies store bit `bit_addr` into the accumulator. Opcode 3 (store) writes the accumulator into store bit `bit_addr` and leaves every other store bit unchanged.
- R3: Opcodes 4, 5 and 6 replace the accumulator with its AND, OR and XOR respectively with store bit `bit_addr`.
- R4: Opcode 7 (add step) sets the accumulator to acc XOR mem XOR carry and the carry to the majority of the three. Opcode 8 clears the carry.
- R5: A 32-bit add across all elements is done in 32 add steps, least significant bit first, with the carry kept between steps. The result equals the sum modulo 2^32 at any chosen operand and result offsets.
- R6: An element with enable flag 0 does not change its store, accumulator or carry. Opcode 9 sets the enable flag to the accumulator, opcode 10 sets it to the inverted accumulator (both only in enabled elements), and opcode 11 sets the enable flag of every element to 1.
- R7: Opcode 12 copies a neighbour's accumulator, using the value before this cycle's update, with `nbr_dir` 0 = north (row-1), 1 = south (row+1), 2 = east (column+1), 3 = west (column-1). Element i sits at row i/4, column i%4. A missing neighbour at the grid edge reads 0.
- R8: `any_acc` is 1 exactly when at least one element has both its enable flag and its accumulator set.
- R9: Opcode 1 copies `lane_in[i]` into the accumulator of element i. Opcode 0 does nothing.
- R10: Every opcode completes in one cycle in all elements together: the new accumulators appear on `acc_out` after the clock edge that samples the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Broadcast opcode |
| bit_addr | input | 12 | Broadcast store bit address |
| nbr_dir | input | 2 | Neighbour direction for opcode 12 |
| lane_in | input | 16 | One private data bit per element for opcode 1 |
| acc_out | output | 16 | Accumulator of every element, bit i from element i |
| any_acc | output | 1 | OR over all enabled elements' accumulators |

## Verification
Neighbour transfer and enable masking can land in the same cycle. A disabled element must keep its own accumulator while its enabled neighbours still take its old value. The bench provokes this by building masks with both enable opcodes and then issuing neighbour reads in each direction. It judges every element's accumulator and the global OR against a bench model after each step. The random instruction stream mixes all opcodes, so masking also meets stores, add steps and the global OR in the same cycle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LANE  = 4'd1,
        OP_LOAD  = 4'd2,
        OP_STORE = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_ADD   = 4'd7,
        OP_CLRC  = 4'd8,
        OP_CTX   = 4'd9,
        OP_CTXN  = 4'd10,
        OP_ALL   = 4'd11,
        OP_NBR   = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_S = 2'd1,
        DIR_E = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef struct packed {
        logic acc;
        logic carry;
        logic ctx;
    } pe_state_t;

    typedef struct packed {
        logic acc;
        logic carry;
    } alu_out_t;

    // One bit-step of the element datapath for register-only opcodes.
    function automatic alu_out_t alu_step(op_e op, logic acc, logic carry,
                                          logic mbit, logic lane, logic nbr);
        alu_out_t r;
        r.acc   = acc;
        r.carry = carry;
        unique case (op)
            OP_LANE: r.acc = lane;
            OP_LOAD: r.acc = mbit;
            OP_AND:  r.acc = acc & mbit;
            OP_OR:   r.acc = acc | mbit;
            OP_XOR:  r.acc = acc ^ mbit;
            OP_ADD: begin
                r.acc   = acc ^ mbit ^ carry;
                r.carry = (acc & mbit) | (acc & carry) | (mbit & carry);
            end
            OP_CLRC: r.carry = 1'b0;
            OP_NBR:  r.acc = nbr;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bsa_nbr_link.sv
module bsa_nbr_link
    import bsa_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int ROW  = 0,
    parameter int COL  = 0,
    localparam int NPE = ROWS * COLS
) (
    input  logic [NPE-1:0] acc_all,
    input  dir_e           dir,
    output logic           nbr_bit
);
    localparam bit HAS_N = (ROW > 0);
    localparam bit HAS_S = (ROW < ROWS - 1);
    localparam bit HAS_E = (COL < COLS - 1);
    localparam bit HAS_W = (COL > 0);
    localparam int IDX_N = HAS_N ? (ROW - 1) * COLS + COL : 0;
    localparam int IDX_S = HAS_S ? (ROW + 1) * COLS + COL : 0;
    localparam int IDX_E = HAS_E ? ROW * COLS + COL + 1 : 0;
    localparam int IDX_W = HAS_W ? ROW * COLS + COL - 1 : 0;

    always_comb begin
        unique case (dir)
            DIR_N:   nbr_bit = HAS_N ? acc_all[IDX_N] : 1'b0;
            DIR_S:   nbr_bit = HAS_S ? acc_all[IDX_S] : 1'b0;
            DIR_E:   nbr_bit = HAS_E ? acc_all[IDX_E] : 1'b0;
            default: nbr_bit = HAS_W ? acc_all[IDX_W] : 1'b0;
        endcase
    end
endmodule

// File: rtl/bsa_pe.sv
module bsa_pe
    import bsa_pkg::*;
#(
    parameter int MEM_BITS = 4096,
    localparam int AW = $clog2(MEM_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  logic [AW-1:0] addr,
    input  logic          lane_bit,
    input  logic          nbr_bit,
    output pe_state_t     st
);
    logic [MEM_BITS-1:0] mem;
    logic                mbit;
    alu_out_t            nxt;

    assign mbit = mem[addr];
    assign nxt  = alu_step(op, st.acc, st.carry, mbit, lane_bit, nbr_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem      <= '0;
            st.acc   <= 1'b0;
            st.carry <= 1'b0;
            st.ctx   <= 1'b1;
        end else if (op == OP_ALL) begin
            st.ctx <= 1'b1;
        end else if (st.ctx) begin
            st.acc   <= nxt.acc;
            st.carry <= nxt.carry;
            if (op == OP_STORE) mem[addr] <= st.acc;
            if (op == OP_CTX)   st.ctx <= st.acc;
            if (op == OP_CTXN)  st.ctx <= ~st.acc;
        end
    end

    // Masked elements keep their store (R6)
    assert_masked_mem_R6: assert property (@(posedge clk) disable iff (rst)
        !st.ctx |=> $stable(mem));
    // Masked elements keep accumulator and carry (R6)
    assert_masked_regs_R6: assert property (@(posedge clk) disable iff (rst)
        !st.ctx |=> ($stable(st.acc) && $stable(st.carry)));
    // The all-enable opcode reaches every element (R6)
    assert_all_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ALL) |=> st.ctx);
    // Clear-carry leaves carry 0 (R4)
    assert_clear_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (st.ctx && op == OP_CLRC) |=> !st.carry);
    // Load takes the addressed bit (R2)
    assert_load_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (st.ctx && op == OP_LOAD) |=> (st.acc == $past(mbit)));
    // Store then load of the same address returns the stored bit (R2)
    assert_store_load_R2: assert property (@(posedge clk) disable iff (rst)
        (st.ctx && op == OP_STORE) |=> (mem[$past(addr)] == $past(st.acc)));
endmodule

// File: rtl/bsa_array.sv
module bsa_array
    import bsa_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int MEM_BITS = 4096,
    localparam int NPE = ROWS * COLS,
    localparam int AW  = $clog2(MEM_BITS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     op,
    input  logic [AW-1:0]  bit_addr,
    input  logic [1:0]     nbr_dir,
    input  logic [NPE-1:0] lane_in,
    output logic [NPE-1:0] acc_out,
    output logic           any_acc
);
    op_e             op_q;
    dir_e            dir_q;
    pe_state_t       st   [NPE];
    logic [NPE-1:0]  ctx_v;
    logic [NPE-1:0]  nbr_v;

    assign op_q  = op_e'(op);
    assign dir_q = dir_e'(nbr_dir);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int I = r * COLS + c;

            bsa_nbr_link #(.ROWS(ROWS), .COLS(COLS), .ROW(r), .COL(c)) u_link (
                .acc_all (acc_out),
                .dir     (dir_q),
                .nbr_bit (nbr_v[I])
            );

            bsa_pe #(.MEM_BITS(MEM_BITS)) u_pe (
                .clk      (clk),
                .rst      (rst),
                .op       (op_q),
                .addr     (bit_addr),
                .lane_bit (lane_in[I]),
                .nbr_bit  (nbr_v[I]),
                .st       (st[I])
            );

            assign acc_out[I] = st[I].acc;
            assign ctx_v[I]   = st[I].ctx;
        end
    end

    assign any_acc = |(acc_out & ctx_v);

    // Lane load fills every enabled element in one cycle (R9, R10)
    assert_lane_load_R9: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_LANE) |=> ((acc_out & $past(ctx_v)) == ($past(lane_in) & $past(ctx_v))));
    // A neighbour read with all elements enabled moves the grid as a whole (R7)
    assert_north_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_NBR && dir_q == DIR_N && &ctx_v)
        |=> (acc_out[NPE-1:COLS] == $past(acc_out[NPE-COLS-1:0]) && acc_out[COLS-1:0] == '0));
endmodule

// File: tb/bsa_array_bench.sv
`timescale 1ns/1ps
module bsa_array_bench;
    import bsa_pkg::*;

    localparam int WIN = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op;
    logic [11:0] bit_addr;
    logic [1:0]  nbr_dir;
    logic [15:0] lane_in;
    logic [15:0] acc_out;
    logic        any_acc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] m_acc, m_c, m_ctx;
    logic [15:0] m_win [16];

    always #2 clk = ~clk;

    bsa_array u_bsa_array (
        .clk(clk), .rst(rst), .op(op), .bit_addr(bit_addr),
        .nbr_dir(nbr_dir), .lane_in(lane_in),
        .acc_out(acc_out), .any_acc(any_acc)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(op_e o, int a, int d, logic [15:0] ln);
        @(negedge clk);
        op = o; bit_addr = a[11:0]; nbr_dir = d[1:0]; lane_in = ln;
        @(posedge clk);
        #1 op = OP_NOP;
    endtask

    function automatic logic nb(logic [15:0] v, int i, int d);
        int r = i / 4;
        int c = i % 4;
        case (d)
            0: return (r > 0) ? v[i-4] : 1'b0;
            1: return (r < 3) ? v[i+4] : 1'b0;
            2: return (c < 3) ? v[i+1] : 1'b0;
            default: return (c > 0) ? v[i-1] : 1'b0;
        endcase
    endfunction

    task automatic model(op_e o, int a, int d, logic [15:0] ln);
        logic [15:0] old = m_acc;
        int w = a - WIN;
        for (int i = 0; i < 16; i++) begin
            logic mb = m_win[i][w];
            if (o == OP_ALL) m_ctx[i] = 1'b1;
            else if (m_ctx[i]) begin
                case (o)
                    OP_LANE:  m_acc[i] = ln[i];
                    OP_LOAD:  m_acc[i] = mb;
                    OP_STORE: m_win[i][w] = old[i];
                    OP_AND:   m_acc[i] = old[i] & mb;
                    OP_OR:    m_acc[i] = old[i] | mb;
                    OP_XOR:   m_acc[i] = old[i] ^ mb;
                    OP_ADD: begin
                        m_acc[i] = old[i] ^ mb ^ m_c[i];
                        m_c[i]   = (old[i] & mb) | (old[i] & m_c[i]) | (mb & m_c[i]);
                    end
                    OP_CLRC:  m_c[i] = 1'b0;
                    OP_CTX:   m_ctx[i] = old[i];
                    OP_CTXN:  m_ctx[i] = ~old[i];
                    OP_NBR:   m_acc[i] = nb(old, i, d);
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(op_e o, int a, int d, logic [15:0] ln, string tag);
        issue(o, a, d, ln);
        model(o, a, d, ln);
        chk(acc_out == m_acc, tag, acc_out, m_acc);
        chk(any_acc == |(m_acc & m_ctx), "R8 global OR", any_acc, |(m_acc & m_ctx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] va [16];
        logic [31:0] vb [16];
        logic [31:0] got [16];
        void'($urandom(32'h5EED));
        rst = 1'b1; op = OP_NOP; bit_addr = '0; nbr_dir = '0; lane_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_acc = '0; m_c = '0; m_ctx = '1;
        for (int i = 0; i < 16; i++) m_win[i] = '0;

        // R1 reset state
        chk(acc_out == 16'h0, "R1 reset accumulators", acc_out, 0);
        chk(any_acc == 1'b0, "R1 reset global OR", any_acc, 0);
        issue(OP_LOAD, 4095, 0, '0);
        chk(acc_out == 16'h0, "R1 reset store cleared", acc_out, 0);
        step(OP_NOP, WIN, 0, 16'hFFFF, "R9 nop has no effect");
        step(OP_LANE, WIN, 0, 16'hFFFF, "R10 all lanes in one cycle");

        // R2 store/load, R3 logic
        step(OP_STORE, WIN + 0, 0, '0, "R2 store");
        step(OP_LANE, WIN, 0, 16'h0000, "R9 lane load");
        step(OP_LOAD, WIN + 0, 0, '0, "R2 load stored bit");
        step(OP_LOAD, WIN + 1, 0, '0, "R2 neighbour bit untouched");
        step(OP_LANE, WIN, 0, 16'h3C3C, "R9 lane load");
        step(OP_AND, WIN + 0, 0, '0, "R3 and");
        step(OP_OR, WIN + 1, 0, '0, "R3 or");
        step(OP_XOR, WIN + 0, 0, '0, "R3 xor");

        // R4 add step and carry clear
        step(OP_LANE, WIN, 0, 16'hFFFF, "R9 lane load");
        step(OP_ADD, WIN + 0, 0, '0, "R4 add with carry out");
        step(OP_LANE, WIN, 0, 16'h0000, "R9 lane load");
        step(OP_ADD, WIN + 1, 0, '0, "R4 carry propagates");
        step(OP_CLRC, WIN, 0, '0, "R4 clear carry");
        step(OP_ADD, WIN + 1, 0, '0, "R4 add after clear");

        // R7 edges in each direction
        for (int d = 0; d < 4; d++) begin
            step(OP_LANE, WIN, 0, 16'hFFFF, "R9 lane load");
            step(OP_NBR, WIN, d, '0, "R7 edge reads zero");
            step(OP_LANE, WIN, 0, 16'h0421, "R9 lane load");
            step(OP_NBR, WIN, d, '0, "R7 neighbour read");
        end

        // R6 masking meeting neighbour reads and global OR
        step(OP_LANE, WIN, 0, 16'h5A5A, "R9 lane load");
        step(OP_CTX, WIN, 0, '0, "R6 enable from acc");
        step(OP_LANE, WIN, 0, 16'hFFFF, "R6 masked lane load");
        step(OP_STORE, WIN + 2, 0, '0, "R6 masked store");
        step(OP_NBR, WIN, 2, '0, "R6 masked neighbour east");
        step(OP_ALL, WIN, 0, '0, "R6 enable all");
        step(OP_LOAD, WIN + 2, 0, '0, "R6 masked store kept");
        step(OP_LANE, WIN, 0, 16'h00FF, "R9 lane load");
        step(OP_CTXN, WIN, 0, '0, "R6 enable from inverted acc");
        step(OP_NBR, WIN, 0, '0, "R7 masked neighbour north");
        step(OP_NBR, WIN, 1, '0, "R7 masked neighbour south");
        step(OP_ALL, WIN, 0, '0, "R6 enable all");

        // Mixed random stream
        for (int n = 0; n < 400; n++) begin
            op_e o = op_e'($urandom_range(1, 12));
            step(o, WIN + $urandom_range(0, 15), $urandom_range(0, 3),
                 16'($urandom), "R3 R6 R7 random stream");
        end
        step(OP_ALL, WIN, 0, '0, "R6 enable all");

        // R5 32-bit add at several offsets
        for (int run = 0; run < 3; run++) begin
            int oa = run * 900 + $urandom_range(0, 100);
            int ob = oa + 200;
            int orr = oa + 400 + $urandom_range(0, 50);
            for (int i = 0; i < 16; i++) begin
                va[i] = $urandom; vb[i] = $urandom;
            end
            if (run == 0) begin
                va[0] = 32'hFFFF_FFFF; vb[0] = 32'h1;
                va[1] = 32'hFFFF_FFFF; vb[1] = 32'hFFFF_FFFF;
                va[2] = 32'h0;         vb[2] = 32'h0;
            end
            for (int k = 0; k < 32; k++) begin
                logic [15:0] la, lb;
                for (int i = 0; i < 16; i++) begin
                    la[i] = va[i][k]; lb[i] = vb[i][k];
                end
                issue(OP_LANE, 0, 0, la); issue(OP_STORE, oa + k, 0, '0);
                issue(OP_LANE, 0, 0, lb); issue(OP_STORE, ob + k, 0, '0);
            end
            issue(OP_CLRC, 0, 0, '0);
            for (int k = 0; k < 32; k++) begin
                issue(OP_LOAD, oa + k, 0, '0);
                issue(OP_ADD, ob + k, 0, '0);
                issue(OP_STORE, orr + k, 0, '0);
            end
            for (int k = 0; k < 32; k++) begin
                issue(OP_LOAD, orr + k, 0, '0);
                for (int i = 0; i < 16; i++) got[i][k] = acc_out[i];
            end
            for (int i = 0; i < 16; i++)
                chk(got[i] == va[i] + vb[i], "R5 32-bit serial add", got[i], va[i] + vb[i]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule